// File: doc/BRIEF.md
# ATA Host Transfer Mode and Reset Controller

This block keeps the transfer timing selection for both devices on a parallel ATA cable and presents it through a 16-bit host control word. Software programs a PIO, multiword DMA or Ultra DMA mode separately for the master and the slave over a small write bus. The settings collect in a 32-bit shadow with one half for each device. They reach the live control word only when the device/head register is written. At that point the half of the newly selected device is copied in. This repairs the control word, which a device/head write can corrupt.

The block also produces two timed pulses on its core clock. One is a soft reset of the host core. The other is a FIFO reset, which can be requested by software or by a bus error indication. The cable type from a sense input is reflected in the control word. ATA bus timing generation and the data path belong to other blocks.

Write bus decode: address 0 is the mode write, address 1 is the device/head write, address 2 is the control write, and address 3 is ignored.

Top module: `ata_mode_ctrl`

## Requirements
- R1: After reset, `sys_ctl_o` and `shadow_o` are all zero and both reset pulses are inactive.
- R2: A mode write (address 0) carries the device in data bit 7 (0 = master, 1 = slave), the class in bits 5:4 (0 PIO, 1 multiword DMA, 2 Ultra DMA) and the mode number in bits 2:0. The addressed device's data code is set as follows. PIO n gives n. Multiword DMA n gives 5+n. Ultra DMA n gives 8+n. The code sits in `shadow_o` bits 7:4 for the master and bits 23:20 for the slave, one cycle after the write.
- R3: A mode write with class 3, PIO above 4, multiword DMA above 2 or Ultra DMA above 5 leaves `shadow_o` unchanged. So does a write to address 3.
- R4: Each device keeps its own last PIO mode, which is 0 after reset. Only PIO writes change it. Both shadow halves carry the smaller of the two PIO modes as the command mode, in bits 10:8 and bits 26:24.
- R5: A device/head write (address 1, device select in data bit 4) made while no soft reset is active loads `sys_ctl_o` bits 10:4 from bits 10:4 of the selected shadow half, one cycle later. Mode writes alone never change `sys_ctl_o` bits 10:4.
- R6: A control write (address 2) with data bit 15 set raises `soft_rst_o` and `sys_ctl_o` bit 15 from the next cycle for exactly SRST_CYCLES cycles. A request made while the pulse is active is ignored.
- R7: A control write with data bit 14 set, or `bus_err_i` high, raises `fifo_rst_o` and `sys_ctl_o` bit 14 for exactly FRST_CYCLES cycles. Requests made while the pulse is active are ignored.
- R8: `sys_ctl_o` bit 13 equals `cable_40_i` delayed by one cycle (1 = 40-conductor, 0 = 80-conductor).
- R9: While the soft reset is active, `sys_ctl_o` bits 10:4 hold their value. Mode and device/head writes still update the shadow and the device selection. In the cycle after the pulse ends, bits 10:4 hold the selected device's half.
- R10: `sys_ctl_o` bits 12:11 and 3:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 mode, 1 device/head, 2 control |
| wr_data_i | input | 16 | Write data |
| bus_err_i | input | 1 | Bus error indication, requests FIFO reset |
| cable_40_i | input | 1 | Cable sense, 1 for 40-conductor |
| sys_ctl_o | output | 16 | Host control word |
| shadow_o | output | 32 | Mode shadow, master half in 15:0, slave half in 31:16 |
| soft_rst_o | output | 1 | Soft reset pulse |
| fifo_rst_o | output | 1 | FIFO reset pulse |

## Verification
Every result is registered once. Shadow contents, control word fields, cable bit and the start of each pulse therefore become visible on the clock edge that accepts the stimulus. A pulse ends exactly SRST_CYCLES or FRST_CYCLES edges after it starts. The deferred mode load lands on the edge where the soft reset drops. The bench drives inputs on falling edges and advances its behavioural model on each rising edge. It compares every output field on the following falling edge, so each expectation is taken one full edge after its cause. Directed checks add explicit pulse widths and literal shadow values.

// File: rtl/ata_mode_pkg.sv
package ata_mode_pkg;
  localparam int NUM_DEV = 2;
  localparam int DEV_W   = $clog2(NUM_DEV);
  localparam int HALF_W  = 16;

  typedef enum logic [1:0] {
    XF_PIO   = 2'd0,
    XF_MWDMA = 2'd1,
    XF_UDMA  = 2'd2,
    XF_RSVD  = 2'd3
  } xfer_class_e;

  localparam logic [1:0] ADDR_MODE    = 2'd0;
  localparam logic [1:0] ADDR_DEVHEAD = 2'd1;
  localparam logic [1:0] ADDR_CTRL    = 2'd2;

  localparam logic [2:0] MAX_PIO   = 3'd4;
  localparam logic [2:0] MAX_MWDMA = 3'd2;
  localparam logic [2:0] MAX_UDMA  = 3'd5;
  localparam logic [3:0] MWDMA_BASE = 4'd5;
  localparam logic [3:0] UDMA_BASE  = 4'd8;

  function automatic logic [HALF_W-1:0] pack_half(logic [2:0] cmd, logic [3:0] code);
    return {5'b0, cmd, code, 4'b0};
  endfunction
endpackage

// File: rtl/ata_mode_shadow.sv
module ata_mode_shadow
  import ata_mode_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [DEV_W-1:0]          dev_i,
  input  xfer_class_e               class_i,
  input  logic [2:0]                num_i,
  output logic [NUM_DEV*HALF_W-1:0] shadow_o
);
  logic       valid;
  logic [3:0] code_new;
  logic [2:0] pio_q  [NUM_DEV];
  logic [3:0] code_q [NUM_DEV];
  logic [2:0] min_pio;

  always_comb begin
    valid    = 1'b0;
    code_new = 4'd0;
    unique case (class_i)
      XF_PIO: begin
        valid    = (num_i <= MAX_PIO);
        code_new = {1'b0, num_i};
      end
      XF_MWDMA: begin
        valid    = (num_i <= MAX_MWDMA);
        code_new = MWDMA_BASE + {1'b0, num_i};
      end
      XF_UDMA: begin
        valid    = (num_i <= MAX_UDMA);
        code_new = UDMA_BASE + {1'b0, num_i};
      end
      default: valid = 1'b0;
    endcase
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = we_i && valid && (dev_i == DEV_W'(d));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pio_q[d]  <= 3'd0;
        code_q[d] <= 4'd0;
      end else if (hit) begin
        code_q[d] <= code_new;
        if (class_i == XF_PIO) pio_q[d] <= num_i;
      end
    end

    assign shadow_o[d*HALF_W +: HALF_W] = pack_half(min_pio, code_q[d]);
  end

  // command timing must suit the slower device on the cable
  always_comb begin
    min_pio = pio_q[0];
    for (int d = 1; d < NUM_DEV; d++)
      if (pio_q[d] < min_pio) min_pio = pio_q[d];
  end
endmodule

// File: rtl/ata_reset_pulse.sv
module ata_reset_pulse #(
  parameter int CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic release_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(CYCLES - 1);
    end
  end

  assign active_o  = active_q;
  assign release_o = active_q && (cnt_q == '0);
endmodule

// File: rtl/ata_mode_ctrl.sv
module ata_mode_ctrl
  import ata_mode_pkg::*;
#(
  parameter int SRST_CYCLES = 20,
  parameter int FRST_CYCLES = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic        bus_err_i,
  input  logic        cable_40_i,
  output logic [15:0] sys_ctl_o,
  output logic [31:0] shadow_o,
  output logic        soft_rst_o,
  output logic        fifo_rst_o
);
  logic mode_we, dh_we, ctl_we;
  logic srst_act, srst_rel, frst_act, frst_rel;
  logic sel_q, sel_d, cable_q;
  logic [6:0]  mode_q;
  logic [15:0] half_d;
  logic [NUM_DEV*HALF_W-1:0] shadow_w;
  logic unused_w;

  assign mode_we = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign dh_we   = wr_en_i && (wr_addr_i == ADDR_DEVHEAD);
  assign ctl_we  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign unused_w = ^{wr_data_i[13:8], wr_data_i[6], wr_data_i[3], frst_rel};

  ata_mode_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mode_we),
    .dev_i    (wr_data_i[7]),
    .class_i  (xfer_class_e'(wr_data_i[5:4])),
    .num_i    (wr_data_i[2:0]),
    .shadow_o (shadow_w)
  );

  ata_reset_pulse #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ctl_we && wr_data_i[15]),
    .active_o  (srst_act),
    .release_o (srst_rel)
  );

  ata_reset_pulse #(.CYCLES(FRST_CYCLES)) u_frst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   ((ctl_we && wr_data_i[14]) || bus_err_i),
    .active_o  (frst_act),
    .release_o (frst_rel)
  );

  assign sel_d  = dh_we ? wr_data_i[4] : sel_q;
  assign half_d = shadow_w[{sel_d, 4'b0} +: HALF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      mode_q  <= '0;
      cable_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      cable_q <= cable_40_i;
      // mode field frozen during soft reset, reapplied on release
      if (srst_act) begin
        if (srst_rel) mode_q <= half_d[10:4];
      end else if (dh_we) begin
        mode_q <= half_d[10:4];
      end
    end
  end

  assign sys_ctl_o  = {srst_act, frst_act, cable_q, 2'b00, mode_q, 4'b0000};
  assign shadow_o   = shadow_w;
  assign soft_rst_o = srst_act;
  assign fifo_rst_o = frst_act;
endmodule

// File: rtl/ata_mode_ctrl_chk.sv
module ata_mode_ctrl_chk #(
  parameter int SRST_CYCLES = 20,
  parameter int FRST_CYCLES = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [15:0] wr_data_i,
  input logic        bus_err_i,
  input logic        cable_40_i,
  input logic [15:0] sys_ctl_o,
  input logic [31:0] shadow_o,
  input logic        soft_rst_o,
  input logic        fifo_rst_o
);
  logic [15:0] srst_len, frst_len;
  logic bad_mode;
  logic unused_w;

  assign unused_w = ^{wr_data_i[15:8], wr_data_i[6], wr_data_i[3], bus_err_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_len <= '0;
      frst_len <= '0;
    end else begin
      srst_len <= soft_rst_o ? srst_len + 1'b1 : 16'd0;
      frst_len <= fifo_rst_o ? frst_len + 1'b1 : 16'd0;
    end
  end

  assign bad_mode = (wr_data_i[5:4] == 2'd3) ||
                    (wr_data_i[5:4] == 2'd0 && wr_data_i[2:0] > 3'd4) ||
                    (wr_data_i[5:4] == 2'd1 && wr_data_i[2:0] > 3'd2) ||
                    (wr_data_i[5:4] == 2'd2 && wr_data_i[2:0] > 3'd5);

  // R6
  srst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst_o) |-> srst_len == 16'(SRST_CYCLES));

  // R7
  frst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fifo_rst_o) |-> frst_len == 16'(FRST_CYCLES));

  // R8
  cable_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sys_ctl_o[13] == $past(cable_40_i));

  // R3
  bad_mode_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0 && bad_mode) |=> $stable(shadow_o));

  // R5
  devhead_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1 && !soft_rst_o) |=>
      sys_ctl_o[10:4] == ($past(wr_data_i[4]) ? $past(shadow_o[26:20]) : $past(shadow_o[10:4])));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_o && $past(soft_rst_o)) |-> $stable(sys_ctl_o[10:4]));

  // R2
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_o[7:4] <= 4'd13) && (shadow_o[23:20] <= 4'd13));
endmodule

bind ata_mode_ctrl ata_mode_ctrl_chk #(
  .SRST_CYCLES(SRST_CYCLES),
  .FRST_CYCLES(FRST_CYCLES)
) u_chk (.*);

// File: tb/ata_mode_ctrl_tb.sv
module ata_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SRST = 20;
  localparam int FRST = 12;

  logic        clk, rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        bus_err, cable;
  logic [15:0] sys_ctl;
  logic [31:0] shadow;
  logic        soft_rst, fifo_rst;

  int tests = 0, fails = 0;

  ata_mode_ctrl #(.SRST_CYCLES(SRST), .FRST_CYCLES(FRST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .bus_err_i(bus_err), .cable_40_i(cable),
    .sys_ctl_o(sys_ctl), .shadow_o(shadow), .soft_rst_o(soft_rst), .fifo_rst_o(fifo_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pio[2], m_code[2], m_sel, m_mode, m_srst, m_frst, m_cable;

  function automatic int half_of(int d);
    int cmd;
    cmd = (m_pio[0] < m_pio[1]) ? m_pio[0] : m_pio[1];
    return (cmd << 8) | (m_code[d] << 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pio = '{0, 0}; m_code = '{0, 0};
      m_sel = 0; m_mode = 0; m_srst = 0; m_frst = 0; m_cable = 0;
    end else begin
      int sel_new, h, cls, num, dv;
      bit mw, dh, cw, ok;
      mw = wr_en && wr_addr == 2'd0;
      dh = wr_en && wr_addr == 2'd1;
      cw = wr_en && wr_addr == 2'd2;
      sel_new = dh ? int'(wr_data[4]) : m_sel;
      h = half_of(sel_new);
      if (m_srst > 0) begin
        if (m_srst == 1) m_mode = (h >> 4) & 8'h7f;
        m_srst--;
      end else begin
        if (dh) m_mode = (h >> 4) & 8'h7f;
        if (cw && wr_data[15]) m_srst = SRST;
      end
      m_sel = sel_new;
      if (m_frst > 0) m_frst--;
      else if ((cw && wr_data[14]) || bus_err) m_frst = FRST;
      if (mw) begin
        cls = int'(wr_data[5:4]); num = int'(wr_data[2:0]); dv = int'(wr_data[7]);
        ok = (cls == 0 && num <= 4) || (cls == 1 && num <= 2) || (cls == 2 && num <= 5);
        if (ok) begin
          if (cls == 0) begin m_pio[dv] = num; m_code[dv] = num; end
          else if (cls == 1) m_code[dv] = 5 + num;
          else m_code[dv] = 8 + num;
        end
      end
      m_cable = int'(cable);
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 soft bit", {31'b0, sys_ctl[15]}, (m_srst > 0) ? 32'd1 : 32'd0);
      check("R6 soft pin", {31'b0, soft_rst},    (m_srst > 0) ? 32'd1 : 32'd0);
      check("R7 fifo bit", {31'b0, sys_ctl[14]}, (m_frst > 0) ? 32'd1 : 32'd0);
      check("R7 fifo pin", {31'b0, fifo_rst},    (m_frst > 0) ? 32'd1 : 32'd0);
      check("R8 cable",    {31'b0, sys_ctl[13]}, 32'(m_cable));
      check("R5 mode field", {25'b0, sys_ctl[10:4]}, 32'(m_mode));
      check("R10 zero bits", {26'b0, sys_ctl[12:11], sys_ctl[3:0]}, 32'd0);
      check("R2 shadow", shadow, 32'((half_of(1) << 16) | half_of(0)));
    end
  end

  // pulse width monitors
  int s_run = 0, s_last = 0, f_run = 0, f_last = 0;
  always @(negedge clk) begin
    if (soft_rst) s_run++; else if (s_run != 0) begin s_last = s_run; s_run = 0; end
    if (fifo_rst) f_run++; else if (f_run != 0) begin f_last = f_run; f_run = 0; end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [15:0] md(int dev, int cls, int num);
    return 16'((dev << 7) | (cls << 4) | num);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; bus_err = 1'b0; cable = 1'b0;
    idle(3);
    // R1
    check("R1 sys_ctl reset", {16'b0, sys_ctl}, 32'd0);
    check("R1 shadow reset", shadow, 32'd0);
    check("R1 pulses idle", {30'b0, soft_rst, fifo_rst}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    cable = 1'b1;
    idle(2);
    check("R8 cable 40", {31'b0, sys_ctl[13]}, 32'd1);

    // R4 / R2 PIO per device
    wr(2'd0, md(0, 0, 4));
    wr(2'd0, md(1, 0, 2));
    check("R4 min pio", shadow, 32'h0220_0240);
    wr(2'd0, md(0, 2, 5));
    check("R2 udma5 master", shadow, 32'h0220_02D0);
    wr(2'd0, md(1, 1, 2));
    check("R2 mwdma2 slave", shadow, 32'h0270_02D0);
    check("R5 no load without devhead", {25'b0, sys_ctl[10:4]}, 32'd0);

    // R3 invalid writes
    wr(2'd0, md(0, 0, 5));
    wr(2'd0, md(1, 1, 3));
    wr(2'd0, md(0, 2, 6));
    wr(2'd0, md(1, 3, 1));
    wr(2'd3, 16'hffff);
    check("R3 invalid ignored", shadow, 32'h0270_02D0);

    // R5 device/head loads
    wr(2'd1, 16'h0010);
    check("R5 slave load", {20'b0, sys_ctl[11:0]}, 32'h270);
    wr(2'd1, 16'h0000);
    check("R5 master load", {20'b0, sys_ctl[11:0]}, 32'h2D0);

    // R6 / R9 soft reset with deferred apply
    wr(2'd2, 16'h8000);
    check("R6 soft active", {31'b0, soft_rst}, 32'd1);
    wr(2'd0, md(0, 0, 3));
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h8000);
    check("R9 mode held", {20'b0, sys_ctl[11:0]}, 32'h2D0);
    check("R9 shadow updated", shadow, 32'h0270_0230);
    idle(SRST);
    check("R6 soft width", 32'(s_last), 32'(SRST));
    check("R9 applied after release", {20'b0, sys_ctl[11:0]}, 32'h270);

    // R7 fifo reset sources
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
    idle(4);
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
    idle(FRST);
    check("R7 bus error width", 32'(f_last), 32'(FRST));
    wr(2'd2, 16'h4000);
    idle(FRST + 2);
    check("R7 ctrl width", 32'(f_last), 32'(FRST));
    wr(2'd2, 16'hC000);
    check("R7 both active", {30'b0, soft_rst, fifo_rst}, 32'd3);
    idle(SRST + 2);
    check("R6 soft width combined", 32'(s_last), 32'(SRST));

    cable = 1'b0;
    idle(2);
    check("R8 cable 80", {31'b0, sys_ctl[13]}, 32'd0);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule